// File: doc/BRIEF.md
# Power-Good Monitor and Power-Cycle Sequencer

This block lives in the always-on real-time-clock domain. It watches two power-good inputs: one from the platform supply and one from the processor regulator. It forms a combined processor power-good from them. When either input falls while the host is running, it starts a host power-cycle reset. For this it pulls three active-low sleep-state outputs (light, medium and deep sleep) low together, holds them there for a programmed multi-second interval, and then lets them go again.

The block also makes a pull-down request for the open-drain DRAM power-good line. The request is derived from the medium-sleep output and a core-well power-good input. A supervisory check raises a sticky error when the platform power-good comes up too soon after the supplies are reported valid.

After the resume-well reset, the block stays powered down until a wake request arrives with both power-good inputs high. Every asynchronous input passes through a two-flop synchronizer before use. A low pulse shorter than one RTC period may therefore go unseen. The hold length is a parameter, and elaboration rejects any value outside 3 to 5 seconds of RTC cycles.

Top module: `pgood_cycle_ctl`

## Requirements
- R1: `cpu_pg` is the AND of the synchronized platform and regulator power-good inputs. A change on either input reaches `cpu_pg` after exactly two RTC clock edges.
- R2: While running, a falling edge on `plat_pg` drives all three sleep outputs low. The edge is seen two edges after the input changes, and the outputs go low one edge later. They stay low for exactly `HOLD_CYCLES` cycles and are released if both power-good inputs are then high.
- R3: A falling edge on `vreg_pg` while running starts the same power cycle, with the same length as in R2.
- R4: `slp_s3_n`, `slp_s4_n` and `slp_s5_n` always carry the same value.
- R5: A falling edge on either power-good input during the hold restarts the hold count. The low pulse then lasts from the first fall to `HOLD_CYCLES` cycles after the later fall.
- R6: If either power-good input is low when the hold ends, the sleep outputs stay low. They are released three edges after the last low input goes high.
- R7: While `rsm_rst` is high, and after its release, the sleep outputs are low, `busy` is 0 and `early_err` is 0, and power-good edges are ignored. The outputs stay low until `wake_req` is seen with both power-good inputs high.
- R8: `busy` is 1 exactly while the hold counter runs. It is 0 once the hold has expired, even if the sleep outputs are still low.
- R9: `dram_pulldn` is 1 (drive the DRAM power-good line low) exactly when `slp_s4_n` is low and the synchronized `core_pg` is 0. Otherwise it is 0, which means the line is released.
- R10: `early_err` goes to 1 when `plat_pg` rises at most `MIN_GOOD_MS` ms (in RTC cycles) after `sup_ok` rises. It then stays 1 until reset. A later rise sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rtc | input | 1 | RTC clock, 32.768 kHz by default |
| rsm_rst | input | 1 | Resume-well reset, active high, asynchronous, synchronized inside |
| plat_pg | input | 1 | Platform supply power-good |
| vreg_pg | input | 1 | Processor regulator power-good |
| core_pg | input | 1 | Core-well power-good |
| sup_ok | input | 1 | Supplies-valid indication |
| wake_req | input | 1 | Wake request, level |
| cpu_pg | output | 1 | Combined processor power-good |
| slp_s3_n | output | 1 | Light sleep output, active low |
| slp_s4_n | output | 1 | Medium sleep output, active low |
| slp_s5_n | output | 1 | Deep sleep output, active low |
| dram_pulldn | output | 1 | 1 = pull DRAM power-good low, 0 = release |
| busy | output | 1 | Hold counter running |
| early_err | output | 1 | Sticky early platform power-good error |

## Verification
The power cycle is triggered separately from the platform input and from the regulator input. This shows that both fall paths lead to the same fixed-length pulse. A second fall inside the hold tells restart apart from ignore by the length of the pulse. An input kept low past the hold tells an automatic release apart from waiting for power-good. The early-rise check is tried with a rise just after the supplies come up and with a rise well outside the window. This separates a correct window from one that is open all the time or never.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

    typedef enum logic [1:0] {
        PS_OFF  = 2'd0,
        PS_ON   = 2'd1,
        PS_HOLD = 2'd2,
        PS_WAIT = 2'd3
    } pwr_state_e;

    typedef struct packed {
        logic plat;
        logic vreg;
        logic core;
        logic sup;
        logic wake;
    } pg_in_t;

    localparam int PG_IN_W = $bits(pg_in_t);

    function automatic int ms_to_ticks(input int ms, input int hz);
        return (ms * hz) / 1000;
    endfunction

    function automatic bit hold_in_range(input int hold, input int hz);
        return (hold >= 3 * hz) && (hold <= 5 * hz);
    endfunction

endpackage

// File: rtl/pgc_sync.sv
module pgc_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        meta <= d;
        q    <= meta;
    end
endmodule

// File: rtl/pgc_edge.sv
module pgc_edge #(
    parameter int W       = 1,
    parameter bit FALLING = 1'b1
) (
    input  logic         clk,
    input  logic [W-1:0] s,
    output logic [W-1:0] hit
);
    logic [W-1:0] prev;

    // prev tracks s even in reset so that no edge appears on release
    always_ff @(posedge clk) prev <= s;

    if (FALLING) begin : g_fall
        assign hit = prev & ~s;
    end else begin : g_rise
        assign hit = s & ~prev;
    end
endmodule

// File: rtl/pgc_seq.sv
module pgc_seq
    import pgc_pkg::*;
#(
    parameter int HOLD_CYCLES = 131072
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       plat,
    input  logic       vreg,
    input  logic       wake,
    input  logic       plat_fall,
    input  logic       vreg_fall,
    output pwr_state_e st
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt;
    pwr_state_e    st_nx;
    logic          cnt_clr;
    logic          both_good;
    logic          any_fall;

    assign both_good = plat & vreg;
    assign any_fall  = plat_fall | vreg_fall;

    always_comb begin
        st_nx   = st;
        cnt_clr = 1'b0;
        unique case (st)
            PS_OFF: begin
                if (wake && both_good) st_nx = PS_ON;
            end
            PS_ON: begin
                if (any_fall) begin
                    st_nx   = PS_HOLD;
                    cnt_clr = 1'b1;
                end
            end
            PS_HOLD: begin
                if (any_fall) begin
                    cnt_clr = 1'b1;
                end else if (cnt == LAST) begin
                    st_nx = both_good ? PS_ON : PS_WAIT;
                end
            end
            PS_WAIT: begin
                if (any_fall) begin
                    st_nx   = PS_HOLD;
                    cnt_clr = 1'b1;
                end else if (both_good) begin
                    st_nx = PS_ON;
                end
            end
            default: st_nx = PS_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= PS_OFF;
            cnt <= '0;
        end else begin
            st <= st_nx;
            if (cnt_clr)            cnt <= '0;
            else if (st == PS_HOLD) cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pgc_early.sv
module pgc_early #(
    parameter int WIN = 3244
) (
    input  logic clk,
    input  logic rst,
    input  logic sup_rise,
    input  logic plat_rise,
    output logic err
);
    localparam int WW = $clog2(WIN + 2);

    logic [WW-1:0] win;
    logic          win_open;

    assign win_open = sup_rise | (win != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            win <= '0;
            err <= 1'b0;
        end else begin
            if (sup_rise)        win <= WW'(WIN);
            else if (win != '0)  win <= win - 1'b1;
            if (plat_rise && win_open) err <= 1'b1;
        end
    end
endmodule

// File: rtl/pgood_cycle_ctl.sv
module pgood_cycle_ctl
    import pgc_pkg::*;
#(
    parameter int RTC_HZ      = 32768,
    parameter int HOLD_CYCLES = 4 * RTC_HZ,
    parameter int MIN_GOOD_MS = 99
) (
    input  logic clk_rtc,
    input  logic rsm_rst,
    input  logic plat_pg,
    input  logic vreg_pg,
    input  logic core_pg,
    input  logic sup_ok,
    input  logic wake_req,
    output logic cpu_pg,
    output logic slp_s3_n,
    output logic slp_s4_n,
    output logic slp_s5_n,
    output logic dram_pulldn,
    output logic busy,
    output logic early_err
);
    localparam int EARLY_WIN = ms_to_ticks(MIN_GOOD_MS, RTC_HZ);

    if (!hold_in_range(HOLD_CYCLES, RTC_HZ)) begin : g_bad_hold
        $error("HOLD_CYCLES must lie between 3 and 5 seconds of RTC cycles");
    end

    pg_in_t     raw_in;
    pg_in_t     syn_in;
    logic       rst_q;
    logic       plat_s, vreg_s, core_s;
    logic       plat_fall, vreg_fall;
    logic       plat_rise, sup_rise;
    logic       run_n;
    pwr_state_e st;

    assign raw_in = '{plat: plat_pg, vreg: vreg_pg, core: core_pg,
                      sup: sup_ok, wake: wake_req};

    pgc_sync #(.W(1)) u_rst_sync (
        .clk (clk_rtc),
        .d   (rsm_rst),
        .q   (rst_q)
    );

    pgc_sync #(.W(PG_IN_W)) u_in_sync (
        .clk (clk_rtc),
        .d   (raw_in),
        .q   (syn_in)
    );

    assign plat_s = syn_in.plat;
    assign vreg_s = syn_in.vreg;
    assign core_s = syn_in.core;

    pgc_edge #(.W(2), .FALLING(1'b1)) u_fall (
        .clk (clk_rtc),
        .s   ({vreg_s, plat_s}),
        .hit ({vreg_fall, plat_fall})
    );

    pgc_edge #(.W(2), .FALLING(1'b0)) u_rise (
        .clk (clk_rtc),
        .s   ({syn_in.sup, plat_s}),
        .hit ({sup_rise, plat_rise})
    );

    pgc_seq #(.HOLD_CYCLES(HOLD_CYCLES)) u_seq (
        .clk       (clk_rtc),
        .rst       (rst_q),
        .plat      (plat_s),
        .vreg      (vreg_s),
        .wake      (syn_in.wake),
        .plat_fall (plat_fall),
        .vreg_fall (vreg_fall),
        .st        (st)
    );

    pgc_early #(.WIN(EARLY_WIN)) u_early (
        .clk       (clk_rtc),
        .rst       (rst_q),
        .sup_rise  (sup_rise),
        .plat_rise (plat_rise),
        .err       (early_err)
    );

    assign run_n       = (st == PS_ON);
    assign slp_s3_n    = run_n;
    assign slp_s4_n    = run_n;
    assign slp_s5_n    = run_n;
    assign busy        = (st == PS_HOLD);
    assign cpu_pg      = plat_s & vreg_s;
    assign dram_pulldn = ~slp_s4_n & ~core_s;

endmodule

// File: rtl/pgc_sva.sv
module pgc_sva
    import pgc_pkg::*;
(
    input logic       clk,
    input logic       rsm_rst,
    input logic       rst_q,
    input logic       plat_pg,
    input logic       vreg_pg,
    input logic       cpu_pg,
    input logic       slp_s3_n,
    input logic       slp_s4_n,
    input logic       slp_s5_n,
    input logic       dram_pulldn,
    input logic       busy,
    input logic       early_err,
    input logic       plat_s,
    input logic       vreg_s,
    input logic       plat_fall,
    input logic       vreg_fall,
    input pwr_state_e st
);
    p_cpu_and_r1: assert property (@(posedge clk) disable iff (rsm_rst || rst_q)
        cpu_pg == ($past(plat_pg, 2) && $past(vreg_pg, 2)));

    p_fall_starts_r2: assert property (@(posedge clk) disable iff (rsm_rst || rst_q)
        (st == PS_ON && (plat_fall || vreg_fall)) |=> busy);

    p_slp_equal_r4: assert property (@(posedge clk)
        (slp_s3_n == slp_s4_n) && (slp_s4_n == slp_s5_n));

    p_release_good_r6: assert property (@(posedge clk) disable iff (rsm_rst || rst_q)
        $rose(slp_s3_n) |-> $past(plat_s && vreg_s));

    p_reset_idle_r7: assert property (@(posedge clk)
        rst_q |=> (!slp_s3_n && !busy && !early_err));

    p_busy_low_r8: assert property (@(posedge clk)
        busy |-> !slp_s3_n);

    p_dram_s4_r9: assert property (@(posedge clk)
        dram_pulldn |-> !slp_s4_n);

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (rsm_rst || rst_q)
        early_err |=> early_err);
endmodule

bind pgood_cycle_ctl pgc_sva u_sva (
    .clk         (clk_rtc),
    .rsm_rst     (rsm_rst),
    .rst_q       (rst_q),
    .plat_pg     (plat_pg),
    .vreg_pg     (vreg_pg),
    .cpu_pg      (cpu_pg),
    .slp_s3_n    (slp_s3_n),
    .slp_s4_n    (slp_s4_n),
    .slp_s5_n    (slp_s5_n),
    .dram_pulldn (dram_pulldn),
    .busy        (busy),
    .early_err   (early_err),
    .plat_s      (plat_s),
    .vreg_s      (vreg_s),
    .plat_fall   (plat_fall),
    .vreg_fall   (vreg_fall),
    .st          (st)
);

// File: tb/pgood_cycle_ctl_bench.sv
module pgood_cycle_ctl_bench;
    localparam int HZ   = 64;
    localparam int HOLD = 4 * HZ;
    localparam int MS   = 99;
    localparam int WIN  = (MS * HZ) / 1000;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rsm_rst, plat_pg, vreg_pg, core_pg, sup_ok, wake_req;
    logic cpu_pg, slp_s3_n, slp_s4_n, slp_s5_n, dram_pulldn, busy, early_err;

    pgood_cycle_ctl #(.RTC_HZ(HZ), .HOLD_CYCLES(HOLD), .MIN_GOOD_MS(MS)) u_pgood_cycle_ctl (
        .clk_rtc(clk), .rsm_rst(rsm_rst), .plat_pg(plat_pg), .vreg_pg(vreg_pg),
        .core_pg(core_pg), .sup_ok(sup_ok), .wake_req(wake_req), .cpu_pg(cpu_pg),
        .slp_s3_n(slp_s3_n), .slp_s4_n(slp_s4_n), .slp_s5_n(slp_s5_n),
        .dram_pulldn(dram_pulldn), .busy(busy), .early_err(early_err)
    );

    int total = 0, bad = 0;
    int exp_q[$];
    int pushed = 0, popped = 0;
    int run = 0, e_len = 0;
    bit eq_ok = 1'b1, mon_en = 1'b0, done = 1'b0;

    task automatic chk(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic push_len(input int n);
        exp_q.push_back(n);
        pushed++;
    endtask

    task automatic wait_pulse();
        while (popped < pushed) cyc(1);
    endtask

    // monitor: measure each low pulse of the sleep outputs, compare to scoreboard
    always @(negedge clk) begin
        if (mon_en) begin
            if (slp_s3_n === 1'b0) begin
                run++;
                if (!(slp_s4_n === slp_s3_n && slp_s5_n === slp_s3_n)) eq_ok = 1'b0;
            end else if (run > 0) begin
                if (exp_q.size() == 0) begin
                    chk("R2 unexpected sleep pulse", run, 0);
                end else begin
                    e_len = exp_q.pop_front();
                    chk("R2/R3/R5/R6 sleep pulse length", run, e_len);
                end
                chk("R4 sleep outputs equal", int'(eq_ok), 1);
                run = 0;
                eq_ok = 1'b1;
                popped++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rsm_rst = 1; plat_pg = 1; vreg_pg = 1; core_pg = 1; sup_ok = 1; wake_req = 0;
        cyc(10);
        chk("R7 reset slp_s3_n", int'(slp_s3_n), 0);
        chk("R7 reset slp_s5_n", int'(slp_s5_n), 0);
        chk("R7 reset busy", int'(busy), 0);
        chk("R7 reset early_err", int'(early_err), 0);
        plat_pg = 0; cyc(5); plat_pg = 1; cyc(5);
        chk("R7 edge ignored in reset busy", int'(busy), 0);
        rsm_rst = 0; cyc(10);
        chk("R7 stays asleep without wake", int'(slp_s4_n), 0);
        chk("R7 busy idle after reset", int'(busy), 0);

        // R10: late rise gives no error, early rise sets it
        plat_pg = 0; sup_ok = 0; cyc(5);
        sup_ok = 1; cyc(WIN + 4); plat_pg = 1; cyc(5);
        chk("R10 late rise no error", int'(early_err), 0);
        plat_pg = 0; sup_ok = 0; cyc(5);
        sup_ok = 1; cyc(2); plat_pg = 1; cyc(5);
        chk("R10 early rise flags", int'(early_err), 1);
        cyc(20);
        chk("R10 error sticky", int'(early_err), 1);
        rsm_rst = 1; cyc(5); rsm_rst = 0; cyc(5);
        chk("R7 reset clears early_err", int'(early_err), 0);

        // R1 while powered down
        vreg_pg = 0; cyc(3);
        chk("R1 vreg low", int'(cpu_pg), 0);
        vreg_pg = 1; plat_pg = 0; cyc(3);
        chk("R1 plat low", int'(cpu_pg), 0);
        plat_pg = 1; cyc(3);
        chk("R1 both high", int'(cpu_pg), 1);
        plat_pg = 0; cyc(1);
        chk("R1 latency one edge", int'(cpu_pg), 1);
        cyc(1);
        chk("R1 latency two edges", int'(cpu_pg), 0);
        cyc(1);

        // R7 wake needs both power-good inputs
        wake_req = 1; cyc(5);
        chk("R7 wake with plat low", int'(slp_s3_n), 0);
        plat_pg = 1; cyc(4);
        chk("R7 wake with both high", int'(slp_s3_n), 1);
        wake_req = 0;
        mon_en = 1'b1;

        // R9 released while running
        core_pg = 0; cyc(4);
        chk("R9 running no pulldown", int'(dram_pulldn), 0);

        // R2 platform fall
        push_len(HOLD);
        plat_pg = 0; cyc(4);
        chk("R8 busy during hold", int'(busy), 1);
        chk("R9 pulldown s4 low core low", int'(dram_pulldn), 1);
        core_pg = 1; cyc(4);
        chk("R9 released with core good", int'(dram_pulldn), 0);
        cyc(10); plat_pg = 1;
        wait_pulse(); cyc(2);
        chk("R8 busy after hold", int'(busy), 0);
        chk("R2 released", int'(slp_s3_n), 1);

        // R3 regulator fall
        push_len(HOLD);
        vreg_pg = 0; cyc(20); vreg_pg = 1;
        wait_pulse(); cyc(2);

        // R5 second fall restarts hold
        push_len(50 + HOLD);
        plat_pg = 0; cyc(10); plat_pg = 1; cyc(40);
        plat_pg = 0; cyc(10); plat_pg = 1;
        wait_pulse(); cyc(2);

        // R6 input still low at hold end
        push_len(HOLD + 40);
        vreg_pg = 0; cyc(HOLD + 20);
        chk("R8 busy low after expiry", int'(busy), 0);
        chk("R6 held while vreg low", int'(slp_s3_n), 0);
        cyc(20); vreg_pg = 1;
        wait_pulse(); cyc(2);

        // R7 reset while running
        mon_en = 1'b0;
        rsm_rst = 1; cyc(4);
        chk("R7 reset while running", int'(slp_s3_n), 0);
        chk("R2 scoreboard drained", exp_q.size(), 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule